// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a software-controlled watchdog with two stages of escalation. A down-counter is loaded from a programmable initial value and drops by one on each strobe of a slow tick enable. When the counter runs out, a timeout flag is raised and the counter reloads itself. If the counter runs out a second time while that flag is still set, a second-timeout flag and a boot flag are raised. At the same moment a one-cycle reset request is sent to the system, unless the no-reboot strap holds it back.

Software reaches the block through a plain 32-bit register bus with per-byte lane enables. Writing to the reload lanes restarts the countdown. Software can halt the counter through the control word, but only until a sticky lock bit is set. Status flags clear when software writes a 1 to them. Writes to either of the two byte-wide data ports raise their own status flag, so software can signal that it is alive.

Top module: `wdt_top`

Register words, where `bus_addr` is the word index:
- Word 0: bits [15:0] are the counter on a read and the reload strobe on a write. Bits [23:16] are the data-in port and bits [31:24] the data-out port.
- Word 1: bits [15:0] are status 1 and bits [31:16] are status 2.
- Word 2: bits [15:0] are control 1 and bits [31:16] are control 2.
- Word 3: four message and scratch bytes; bits [31:24] are the interrupt-select byte.
- Word 4: bits [15:0] are the initial value.

## Requirements
- R1: After reset, reads return the following: word 2 = 0x00080000, word 3 = 0x03000000, word 4 = 0x00000004. Words 0 and 1 read 0.
- R2: The initial value field is 10 bits wide. Writing 0xFFFF to word 4 bits [15:0] reads back 0x03FF.
- R3: A write with lane 0 or lane 1 enabled on word 0 copies the initial value into the counter, with a value of 0 loaded as 1. Word 0 bits [15:0] return the counter. After reset the counter is 0, and ticks leave it at 0 until the first reload.
- R4: Each cycle with `tick_en` high lowers a nonzero counter by exactly one while the halt bit (control 1, bit 11) is clear. While the halt bit is set the counter holds its value. A reload in the same cycle as a tick wins.
- R5: A tick that finds the counter at 1 sets the timeout flag (status 1, bit 3) and reloads the counter from the initial value.
- R6: An expiry that finds the timeout flag already set also sets the second-timeout flag (status 2, bit 1) and the boot flag (status 2, bit 2).
- R7: That second expiry drives `rst_req` high for the following cycle when `no_reboot` is low. When `no_reboot` is high, `rst_req` stays low.
- R8: Each status flag clears when a 1 is written to its bit with its byte lane enabled. Writing back the word just read returns both status halves to 0. A set in the same cycle as a clear wins.
- R9: A write to word 0 lane 2 stores the byte and sets status 1 bit 1. A write to lane 3 stores the byte and sets status 1 bit 2. Neither write reloads the counter.
- R10: Writing a 1 to control 1 bit 12 sets the lock. The lock stays set until reset, it forces the halt bit to 0, and later halt writes are ignored.
- R11: Word 1 returns status 2 in bits [31:16] and status 1 in bits [15:0]. Word 2 returns control 2 in bits [31:16] and control 1 in bits [15:0]. The other control bits are plain storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| tick_en | input | 1 | One-cycle strobe per watchdog tick |
| no_reboot | input | 1 | Suppresses the reset request when high |
| rst_req | output | 1 | One-cycle reset request on a second expiry |

## Verification
Every read word is combinational on the current state. A wrong counter, flag or control bit therefore shows on `bus_rdata` in the same cycle that the bad value is registered, as long as the bench is addressing that word. The reset request is registered, so a missed or spurious escalation shows on `rst_req` exactly one cycle after the expiring tick. Comparing the addressed word and `rst_req` against a model on every clock catches a divergence within a cycle of its cause.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int BUS_W = 32;
    localparam int BE_W  = BUS_W / 8;

    localparam int W_CNT  = 0;
    localparam int W_STS  = 1;
    localparam int W_CTL  = 2;
    localparam int W_MSG  = 3;
    localparam int W_INIT = 4;

    localparam int HALT_BIT = 11;
    localparam int LOCK_BIT = 12;
    localparam int TMO_BIT  = 3;
    localparam int SMI_BIT  = 1;
    localparam int INT_BIT  = 2;
    localparam int SEC_BIT  = 1;
    localparam int BOOT_BIT = 2;

    localparam logic [15:0] CTL2_RST  = 16'h0008;
    localparam logic [15:0] INIT_RST  = 16'h0004;
    localparam logic [7:0]  IRQSEL_RST = 8'h03;
endpackage

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        st_d     = st_q;
        expire   = 1'b0;
        load_val = (init_val == '0) ? CNT_W'(1) : init_val;
        if (reload) begin
            st_d.cnt = load_val;
        end else if (tick && !halt && st_q.cnt != '0) begin
            if (st_q.cnt == CNT_W'(1)) begin
                expire   = 1'b1;
                st_d.cnt = load_val;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/wdt_status.sv
module wdt_status
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        expire,
    input  logic        no_reboot,
    input  logic        clr_tmo,
    input  logic        clr_smi,
    input  logic        clr_int,
    input  logic        clr_sec,
    input  logic        clr_boot,
    input  logic        set_smi,
    input  logic        set_int,
    output logic [15:0] sts1,
    output logic [15:0] sts2,
    output logic        rst_req
);
    typedef struct packed {
        logic tmo;
        logic smi;
        logic intr;
        logic sec;
        logic boot;
        logic rreq;
    } sts_t;

    sts_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rreq = 1'b0;
        if (clr_tmo)  st_d.tmo  = 1'b0;
        if (clr_smi)  st_d.smi  = 1'b0;
        if (clr_int)  st_d.intr = 1'b0;
        if (clr_sec)  st_d.sec  = 1'b0;
        if (clr_boot) st_d.boot = 1'b0;
        if (set_smi)  st_d.smi  = 1'b1;
        if (set_int)  st_d.intr = 1'b1;
        if (expire) begin
            if (st_q.tmo) begin
                st_d.sec  = 1'b1;
                st_d.boot = 1'b1;
                st_d.rreq = !no_reboot;
            end
            st_d.tmo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sts1           = '0;
        sts1[TMO_BIT]  = st_q.tmo;
        sts1[SMI_BIT]  = st_q.smi;
        sts1[INT_BIT]  = st_q.intr;
        sts2           = '0;
        sts2[SEC_BIT]  = st_q.sec;
        sts2[BOOT_BIT] = st_q.boot;
    end

    assign rst_req = st_q.rreq;
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic             wr_ctl,
    input  logic             wr_msg,
    input  logic             wr_init,
    input  logic [BE_W-1:0]  be,
    input  logic [BUS_W-1:0] wd,
    output logic [15:0]      ctl1,
    output logic [15:0]      ctl2,
    output logic [31:0]      msg,
    output logic [15:0]      init,
    output logic [7:0]       din,
    output logic [7:0]       dout,
    output logic             halt,
    output logic             lock
);
    localparam logic [15:0] INIT_MASK = 16'((32'd1 << CNT_W) - 1);

    typedef struct packed {
        logic [15:0] ctl1;
        logic [15:0] ctl2;
        logic [31:0] msg;
        logic [15:0] init;
        logic [7:0]  din;
        logic [7:0]  dout;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [15:0] init_new;
    logic        lock_nx;

    always_comb begin
        st_d     = st_q;
        init_new = st_q.init;
        lock_nx  = st_q.ctl1[LOCK_BIT];
        if (wr_cnt) begin
            if (be[2]) st_d.din  = wd[23:16];
            if (be[3]) st_d.dout = wd[31:24];
        end
        if (wr_ctl) begin
            if (be[0]) st_d.ctl1[7:0] = wd[7:0];
            if (be[1]) begin
                lock_nx            = st_q.ctl1[LOCK_BIT] | wd[LOCK_BIT];
                st_d.ctl1[15:8]    = wd[15:8];
                st_d.ctl1[LOCK_BIT] = lock_nx;
                st_d.ctl1[HALT_BIT] = lock_nx ? 1'b0 : wd[HALT_BIT];
            end
            if (be[2]) st_d.ctl2[7:0]  = wd[23:16];
            if (be[3]) st_d.ctl2[15:8] = wd[31:24];
        end
        if (wr_msg) begin
            for (int b = 0; b < BE_W; b++) begin
                if (be[b]) st_d.msg[b*8 +: 8] = wd[b*8 +: 8];
            end
        end
        if (wr_init) begin
            if (be[0]) init_new[7:0]  = wd[7:0];
            if (be[1]) init_new[15:8] = wd[15:8];
            st_d.init = init_new & INIT_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctl2 <= CTL2_RST;
            st_q.init <= INIT_RST;
            st_q.msg  <= {IRQSEL_RST, 24'h0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl1 = st_q.ctl1;
    assign ctl2 = st_q.ctl2;
    assign msg  = st_q.msg;
    assign init = st_q.init;
    assign din  = st_q.din;
    assign dout = st_q.dout;
    assign halt = st_q.ctl1[HALT_BIT];
    assign lock = st_q.ctl1[LOCK_BIT];
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    input  logic              no_reboot,
    output logic              rst_req
);
    logic [BUS_W-1:0] lane_mask, wmask;
    logic wr_cnt, wr_sts, wr_ctl, wr_msg, wr_init, reload, expire;
    logic halt, lock;
    logic [CNT_W-1:0] cnt;
    logic [15:0] sts1, sts2, ctl1, ctl2, init;
    logic [31:0] msg;
    logic [7:0]  din, dout;

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{bus_be[g]}};
    end
    assign wmask = bus_wdata & lane_mask;

    assign wr_cnt  = bus_wr && (bus_addr == ADDR_W'(W_CNT));
    assign wr_sts  = bus_wr && (bus_addr == ADDR_W'(W_STS));
    assign wr_ctl  = bus_wr && (bus_addr == ADDR_W'(W_CTL));
    assign wr_msg  = bus_wr && (bus_addr == ADDR_W'(W_MSG));
    assign wr_init = bus_wr && (bus_addr == ADDR_W'(W_INIT));
    assign reload  = wr_cnt && (bus_be[0] || bus_be[1]);

    wdt_cfg #(.CNT_W(CNT_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl),
        .wr_msg(wr_msg), .wr_init(wr_init), .be(bus_be), .wd(wmask),
        .ctl1(ctl1), .ctl2(ctl2), .msg(msg), .init(init),
        .din(din), .dout(dout), .halt(halt), .lock(lock)
    );

    wdt_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .halt(halt),
        .reload(reload), .init_val(init[CNT_W-1:0]),
        .count(cnt), .expire(expire)
    );

    wdt_status sts_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .no_reboot(no_reboot),
        .clr_tmo (wr_sts && wmask[TMO_BIT]),
        .clr_smi (wr_sts && wmask[SMI_BIT]),
        .clr_int (wr_sts && wmask[INT_BIT]),
        .clr_sec (wr_sts && wmask[16+SEC_BIT]),
        .clr_boot(wr_sts && wmask[16+BOOT_BIT]),
        .set_smi (wr_cnt && bus_be[2]),
        .set_int (wr_cnt && bus_be[3]),
        .sts1(sts1), .sts2(sts2), .rst_req(rst_req)
    );

    always_comb begin
        case (bus_addr)
            ADDR_W'(W_CNT):  bus_rdata = {dout, din, 16'(cnt)};
            ADDR_W'(W_STS):  bus_rdata = {sts2, sts1};
            ADDR_W'(W_CTL):  bus_rdata = {ctl2, ctl1};
            ADDR_W'(W_MSG):  bus_rdata = msg;
            ADDR_W'(W_INIT): bus_rdata = {16'h0, init};
            default:         bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             halt,
    input logic             lock,
    input logic             tick_en,
    input logic             reload,
    input logic             expire,
    input logic             tmo,
    input logic             sec,
    input logic             no_reboot,
    input logic             rst_req
);
    a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(count));

    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !halt && !reload && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

    a_r5_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tmo);

    a_r6_second_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec) |-> $past(tmo && expire));

    a_r7_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(expire && tmo && !no_reboot));

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    a_r10_lock_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !halt);
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .count(cnt), .halt(halt), .lock(lock),
    .tick_en(tick_en), .reload(reload), .expire(expire),
    .tmo(sts1[3]), .sec(sts2[1]), .no_reboot(no_reboot), .rst_req(rst_req)
);

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        no_reboot = 1'b0;
    logic        rst_req;

    int n_cmp = 0, n_bad = 0, cyc = 0, pulses = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt, m_init, m_ctl1, m_ctl2, m_msg, m_din, m_dout;
    bit m_tmo, m_smi, m_int, m_sec, m_boot, m_rreq;

    always #5 clk = ~clk;

    wdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .no_reboot(no_reboot), .rst_req(rst_req)
    );

    function automatic logic [31:0] m_read(int a);
        case (a)
            0: return {m_dout[7:0], m_din[7:0], m_cnt[15:0]};
            1: return {13'h0, m_boot, m_sec, 1'b0, 12'h0, m_tmo, m_int, m_smi, 1'b0};
            2: return {m_ctl2[15:0], m_ctl1[15:0]};
            3: return m_msg;
            4: return {16'h0, m_init[15:0]};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_init = 4; m_ctl1 = 0; m_ctl2 = 8; m_msg = 32'h03000000;
            m_din = 0; m_dout = 0;
            {m_tmo, m_smi, m_int, m_sec, m_boot, m_rreq} = '0;
        end else begin
            bit old_tmo, exp_now, wc;
            int ld, ini16;
            old_tmo = m_tmo; exp_now = 0; m_rreq = 0;
            wc = bus_wr && bus_addr == 0;
            ld = (m_init == 0) ? 1 : m_init;
            if (wc && (bus_be[0] || bus_be[1])) m_cnt = ld;
            else if (tick_en && m_ctl1[11] == 0 && m_cnt != 0) begin
                if (m_cnt == 1) begin exp_now = 1; m_cnt = ld; end
                else m_cnt = m_cnt - 1;
            end
            if (bus_wr && bus_addr == 1) begin
                if (bus_be[0] && bus_wdata[3]) m_tmo = 0;
                if (bus_be[0] && bus_wdata[1]) m_smi = 0;
                if (bus_be[0] && bus_wdata[2]) m_int = 0;
                if (bus_be[2] && bus_wdata[17]) m_sec = 0;
                if (bus_be[2] && bus_wdata[18]) m_boot = 0;
            end
            if (wc && bus_be[2]) begin m_smi = 1; m_din = bus_wdata[23:16]; end
            if (wc && bus_be[3]) begin m_int = 1; m_dout = bus_wdata[31:24]; end
            if (exp_now) begin
                if (old_tmo) begin m_sec = 1; m_boot = 1; m_rreq = !no_reboot; end
                m_tmo = 1;
            end
            if (bus_wr && bus_addr == 2) begin
                if (bus_be[0]) m_ctl1[7:0] = bus_wdata[7:0];
                if (bus_be[1]) begin
                    bit lk;
                    lk = m_ctl1[12] | bus_wdata[12];
                    m_ctl1[15:8] = bus_wdata[15:8];
                    m_ctl1[12] = lk;
                    m_ctl1[11] = lk ? 1'b0 : bus_wdata[11];
                end
                if (bus_be[2]) m_ctl2[7:0] = bus_wdata[23:16];
                if (bus_be[3]) m_ctl2[15:8] = bus_wdata[31:24];
            end
            if (bus_wr && bus_addr == 3)
                for (int b = 0; b < 4; b++) if (bus_be[b]) m_msg[b*8 +: 8] = bus_wdata[b*8 +: 8];
            if (bus_wr && bus_addr == 4) begin
                ini16 = m_init;
                if (bus_be[0]) ini16[7:0] = bus_wdata[7:0];
                if (bus_be[1]) ini16[15:8] = bus_wdata[15:8];
                m_init = ini16 & 32'h3FF;
            end
        end
        if (cyc > 100000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired: actual cycles %0d expected below 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) if (rst_n) begin
        logic [31:0] e;
        string tag;
        e = m_read(int'(bus_addr));
        case (bus_addr)
            0: tag = "R3"; 1: tag = "R8"; 2: tag = "R10"; 3: tag = "R1"; default: tag = "R2";
        endcase
        n_cmp++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s word %0d: actual %h expected %h", tag, bus_addr, bus_rdata, e);
        end
        n_cmp++;
        if (rst_req !== m_rreq) begin
            n_bad++;
            $display("FAIL R7 rst_req: actual %b expected %b", rst_req, m_rreq);
        end
        if (rst_req === 1'b1) pulses++;
    end

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk); #1;
        bus_wr = 1; bus_addr = 3'(a); bus_wdata = d; bus_be = be;
        @(negedge clk); #1;
        bus_wr = 0; bus_be = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1; tick_en = 1;
        end
        @(negedge clk); #1; tick_en = 0;
    endtask

    task automatic expect_word(input int a, input logic [31:0] e, input string tag);
        @(negedge clk); #1;
        bus_addr = 3'(a);
        #1;
        n_cmp++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s word %0d: actual %h expected %h", tag, a, bus_rdata, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1 reset values
        expect_word(0, 32'h0, "R1");
        expect_word(1, 32'h0, "R1");
        expect_word(2, 32'h00080000, "R1");
        expect_word(3, 32'h03000000, "R1");
        expect_word(4, 32'h00000004, "R1");
        ticks(3);
        expect_word(0, 32'h0, "R3");               // unarmed counter ignores ticks
        // R2 masking
        wr(4, 32'h0000FFFF, 4'b0011);
        expect_word(4, 32'h000003FF, "R2");
        // R3 zero loads as one
        wr(4, 32'h0, 4'b0011);
        wr(0, 32'h0, 4'b0001);
        expect_word(0, 32'h00000001, "R3");
        wr(4, 32'h5, 4'b0011);
        wr(0, 32'h0, 4'b0010);
        expect_word(0, 32'h00000005, "R3");
        // R4 countdown and halt
        ticks(2);
        expect_word(0, 32'h00000003, "R4");
        wr(2, 32'h00000800, 4'b0010);
        ticks(3);
        expect_word(0, 32'h00000003, "R4");
        wr(2, 32'h0, 4'b0010);
        ticks(2);
        expect_word(0, 32'h00000001, "R4");
        expect_word(1, 32'h0, "R5");
        // R5 first expiry
        ticks(1);
        expect_word(1, 32'h00000008, "R5");
        expect_word(0, 32'h00000005, "R5");
        // R8 clear by writing back
        wr(1, 32'h00000008, 4'b0001);
        expect_word(1, 32'h0, "R8");
        // R6 second expiry with reboot suppressed
        no_reboot = 1;
        ticks(5);
        ticks(5);
        expect_word(1, 32'h00060008, "R6");
        expect_word(1, 32'h00060008, "R11");
        n_cmp++;
        if (pulses != 0) begin n_bad++; $display("FAIL R7 pulses: actual %0d expected 0", pulses); end
        wr(1, 32'h00060008, 4'b1111);
        expect_word(1, 32'h0, "R8");
        // R7 second expiry with reboot allowed
        no_reboot = 0;
        ticks(5);
        ticks(5);
        repeat (2) @(negedge clk);
        n_cmp++;
        if (pulses != 1) begin n_bad++; $display("FAIL R7 pulses: actual %0d expected 1", pulses); end
        wr(1, 32'h00060008, 4'b1111);
        // R9 data ports
        wr(0, 32'hA55A0000, 4'b1100);
        expect_word(1, 32'h00000006, "R9");
        expect_word(0, 32'hA55A0005, "R9");
        wr(1, 32'h00000006, 4'b0001);
        expect_word(1, 32'h0, "R8");
        // R10 lock
        wr(2, 32'h00001800, 4'b0010);
        expect_word(2, 32'h00081000, "R10");
        wr(2, 32'h00000000, 4'b0010);
        wr(2, 32'h00000800, 4'b0010);
        expect_word(2, 32'h00081000, "R10");
        ticks(1);
        expect_word(0, 32'hA55A0004, "R10");
        // R11 layout of control word
        wr(2, 32'h00AB0000, 4'b1100);
        expect_word(2, 32'h00AB1000, "R11");
        wr(3, 32'h11223344, 4'b1111);
        expect_word(3, 32'h11223344, "R11");
        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule